// File: doc/BRIEF.md
# Interconnect Test Vector Generator

This block produces the parallel stimulus for a boundary-scan interconnect test over a set of board nets, and it checks the responses that come back. Each net gets a fixed code word: net i uses the binary value i+1. The block sends one vector per handshake. Vector k holds bit k of every net's code, so the block needs only a logarithmic number of vectors. Because no net gets the all-zero or all-one code, every net is driven both low and high. Because no two nets share a code, every pair of nets is driven to opposite values in at least one vector. That is enough to expose any short, including shorts between more than two nets.

A start pulse begins a test. The block then offers the vectors in order, raises a last flag on the final one, and goes quiet once that vector is accepted. Captured response vectors come back on a separate strobe in the same order. The block rebuilds each net's received word from them. Once a full set has arrived, it flags every net whose word differs from its own code, and it raises one flag when a received word equals the code of some other net. Placing vectors onto scan-chain bit positions and the serial shifting are left to the surrounding logic.

Top module: `net_probe_gen`

## Requirements
- R1: After reset, vecValid, vecLast, resultValid, shortSeen and every faultNets bit are 0.
- R2: A start pulse sampled at a clock edge makes vecValid 1 from that edge on, with vector index 0. Start takes priority over every other input in that cycle.
- R3: The set holds VEC_COUNT = ceil(log2(NUM_NETS+2)) vectors. In vector k (k = 0 first), bit i of vecData equals bit k of the integer i+1, so the least significant code bit is sent first.
- R4: vecLast is 1 only while vector VEC_COUNT-1 is offered. After that vector is accepted (vecValid and vecReady at an edge), vecValid is 0 until the next start.
- R5: While vecValid is 1 and vecReady is 0, the offered vecData and vecLast do not change and vecValid stays 1.
- R6: Over one full set, every net sees a 0 and a 1, and every pair of nets is driven to opposite values in at least one vector.
- R7: Each edge with respValid 1 and no start captures respData as the next response vector. After VEC_COUNT captures, resultValid is 1 and stays 1 until the next start. Further responses are ignored. A start clears all captured data.
- R8: With resultValid at 1, faultNets bit i is 1 exactly when the received word of net i (response k giving bit k) differs from i+1. With resultValid at 0, all faultNets bits are 0.
- R9: With resultValid at 1, shortSeen is 1 exactly when the received word of some net i equals j+1 for a net j other than i. With resultValid at 0, shortSeen is 0.
- R10: A start during an unfinished set or capture restarts at vector 0 and discards all responses captured so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins or restarts a test |
| vecReady | input | 1 | Consumer accepts the offered vector |
| vecValid | output | 1 | A vector is offered |
| vecData | output | NUM_NETS | Offered vector, one bit per net |
| vecLast | output | 1 | Offered vector is the final one of the set |
| respValid | input | 1 | A captured response vector is present |
| respData | input | NUM_NETS | Captured response vector, one bit per net |
| resultValid | output | 1 | A full response set has been received |
| faultNets | output | NUM_NETS | Per-net mismatch against its own code |
| shortSeen | output | 1 | A received word equals another net's code |

## Verification
The bench builds the block with NUM_NETS = 6. That gives three vectors, and the six codes fill every three-bit value except all-zero and all-one. With this setting NUM_NETS+2 is exactly a power of two, the tightest case for the vector count. The bench uses stuck nets and out-of-range words to reach the fault flags, and uses wired-OR merges and a word copied from another net to reach the short flag. It varies the consumer's ready pattern from always-ready to toggling and pseudo-random, which tests the hold behaviour. It also restarts in the middle of both the vector stream and the response capture.

// File: rtl/net_probe_pkg.sv
package net_probe_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // wipe captured response words
    logic capture;  // shift in one response vector
  } probeStrobe_t;
endpackage

// File: rtl/net_probe_ctrl.sv
module net_probe_ctrl
  import net_probe_pkg::*;
#(
  parameter int VEC_COUNT = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vecReady,
  input  logic             respValid,
  output logic             vecValid,
  output logic             vecLast,
  output logic [IDX_W-1:0] vecIdx,
  output logic             resultValid,
  output probeStrobe_t     strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(VEC_COUNT - 1);
  localparam logic [IDX_W-1:0] FULL_CNT  = IDX_W'(VEC_COUNT);

  logic             active;
  logic [IDX_W-1:0] capCount;
  logic             atLast;
  logic             takeResp;

  assign atLast   = (vecIdx == LAST_IDX);
  assign takeResp = respValid && !start && (capCount != FULL_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      vecIdx   <= '0;
      capCount <= '0;
    end else if (start) begin
      active   <= 1'b1;
      vecIdx   <= '0;
      capCount <= '0;
    end else begin
      if (active && vecReady) begin
        if (atLast) active <= 1'b0;
        else        vecIdx <= vecIdx + 1'b1;
      end
      if (takeResp) capCount <= capCount + 1'b1;
    end
  end

  assign vecValid       = active;
  assign vecLast        = active && atLast;
  assign resultValid    = (capCount == FULL_CNT);
  assign strobe.clear   = start;
  assign strobe.capture = takeResp;
endmodule

// File: rtl/net_probe_dp.sv
module net_probe_dp
  import net_probe_pkg::*;
#(
  parameter int NUM_NETS  = 8,
  parameter int VEC_COUNT = 4,
  parameter int IDX_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  probeStrobe_t        strobe,
  input  logic [IDX_W-1:0]    vecIdx,
  input  logic                resultValid,
  input  logic [NUM_NETS-1:0] respData,
  output logic [NUM_NETS-1:0] vecData,
  output logic [NUM_NETS-1:0] faultNets,
  output logic                shortSeen
);
  logic [NUM_NETS-1:0] mismatch;
  logic [NUM_NETS-1:0] aliasHit;

  for (genvar i = 0; i < NUM_NETS; i++) begin : g_net
    localparam logic [VEC_COUNT-1:0] CODE = VEC_COUNT'(i + 1);

    logic [VEC_COUNT-1:0] shifted;
    logic [VEC_COUNT-1:0] word;
    logic                 hit;

    // Stimulus bit: bit vecIdx of this net's code
    assign shifted    = CODE >> vecIdx;
    assign vecData[i] = shifted[0];

    // Received word, first response lands in bit 0 after a full set
    always_ff @(posedge clk) begin
      if (!rst_n)              word <= '0;
      else if (strobe.clear)   word <= '0;
      else if (strobe.capture) word <= {respData[i], word[VEC_COUNT-1:1]};
    end

    assign mismatch[i] = (word != CODE);

    always_comb begin
      hit = 1'b0;
      for (int j = 0; j < NUM_NETS; j++) begin
        if ((j != i) && (word == VEC_COUNT'(j + 1))) hit = 1'b1;
      end
    end
    assign aliasHit[i] = hit;
  end

  assign faultNets = resultValid ? mismatch : '0;
  assign shortSeen = resultValid && (|aliasHit);
endmodule

// File: rtl/net_probe_gen.sv
module net_probe_gen
  import net_probe_pkg::*;
#(
  parameter int NUM_NETS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                vecReady,
  output logic                vecValid,
  output logic [NUM_NETS-1:0] vecData,
  output logic                vecLast,
  input  logic                respValid,
  input  logic [NUM_NETS-1:0] respData,
  output logic                resultValid,
  output logic [NUM_NETS-1:0] faultNets,
  output logic                shortSeen
);
  localparam int VEC_COUNT = $clog2(NUM_NETS + 2);
  localparam int IDX_W     = $clog2(VEC_COUNT + 1);

  logic [IDX_W-1:0] vecIdx;
  probeStrobe_t     strobe;

  net_probe_ctrl #(
    .VEC_COUNT(VEC_COUNT),
    .IDX_W    (IDX_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vecReady   (vecReady),
    .respValid  (respValid),
    .vecValid   (vecValid),
    .vecLast    (vecLast),
    .vecIdx     (vecIdx),
    .resultValid(resultValid),
    .strobe     (strobe)
  );

  net_probe_dp #(
    .NUM_NETS (NUM_NETS),
    .VEC_COUNT(VEC_COUNT),
    .IDX_W    (IDX_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .vecIdx     (vecIdx),
    .resultValid(resultValid),
    .respData   (respData),
    .vecData    (vecData),
    .faultNets  (faultNets),
    .shortSeen  (shortSeen)
  );
endmodule

// File: rtl/net_probe_sva.sv
module net_probe_sva #(
  parameter int NUM_NETS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                vecReady,
  input logic                vecValid,
  input logic [NUM_NETS-1:0] vecData,
  input logic                vecLast,
  input logic                respValid,
  input logic                resultValid,
  input logic [NUM_NETS-1:0] faultNets,
  input logic                shortSeen
);
  assert_last_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vecLast |-> vecValid);

  assert_drop_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && vecReady && vecLast && !start) |=> !vecValid);

  assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !vecReady && !start) |=> (vecValid && $stable(vecData) && $stable(vecLast)));

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vecValid && !vecLast && !resultValid));

  assert_quiet_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> (faultNets == '0 && !shortSeen));

  assert_result_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && !start) |=> resultValid);
endmodule

bind net_probe_gen net_probe_sva #(.NUM_NETS(NUM_NETS)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .vecReady   (vecReady),
  .vecValid   (vecValid),
  .vecData    (vecData),
  .vecLast    (vecLast),
  .respValid  (respValid),
  .resultValid(resultValid),
  .faultNets  (faultNets),
  .shortSeen  (shortSeen)
);

// File: tb/net_probe_gen_tb_top.sv
`timescale 1ns/1ps
module net_probe_gen_tb_top;
  localparam int NB = 6;
  localparam int VC = 3;  // ceil(log2(NB+2))

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          vecReady = 1'b0;
  logic          respValid = 1'b0;
  logic [NB-1:0] respData = '0;
  logic          vecValid, vecLast, resultValid, shortSeen;
  logic [NB-1:0] vecData, faultNets;

  net_probe_gen #(.NUM_NETS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vecReady(vecReady),
    .vecValid(vecValid), .vecData(vecData), .vecLast(vecLast),
    .respValid(respValid), .respData(respData), .resultValid(resultValid),
    .faultNets(faultNets), .shortSeen(shortSeen)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  task automatic checkEq(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit mActive = 0;
  int mIdx = 0;
  int mCnt = 0;
  int mRecv[NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      mActive = 0; mIdx = 0; mCnt = 0;
      for (int i = 0; i < NB; i++) mRecv[i] = 0;
    end else if (start) begin
      mActive = 1; mIdx = 0; mCnt = 0;
      for (int i = 0; i < NB; i++) mRecv[i] = 0;
    end else begin
      if (mActive && vecReady) begin
        if (mIdx == VC - 1) mActive = 0;
        else mIdx++;
      end
      if (respValid && mCnt < VC) begin
        for (int i = 0; i < NB; i++) mRecv[i] |= (int'(respData[i]) << mCnt);
        mCnt++;
      end
    end
  end

  // ---------------- ready pattern ----------------
  int readyMode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (readyMode)
      0: vecReady = 1'b1;
      1: vecReady = ~vecReady;
      default: vecReady = lfsr[0];
    endcase
  end

  // ---------------- per-cycle comparison ----------------
  logic [NB-1:0] acc[VC + 4];
  int accCount = 0;
  bit holdPending = 0;
  logic [NB-1:0] holdData;
  logic holdLast;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NB-1:0] eData, eFault;
      bit eDone, eShort;
      for (int i = 0; i < NB; i++) eData[i] = ((i + 1) >> mIdx) & 1;
      eDone = (mCnt == VC);
      eShort = 0;
      for (int i = 0; i < NB; i++) begin
        eFault[i] = eDone && (mRecv[i] != i + 1);
        for (int j = 0; j < NB; j++)
          if (eDone && j != i && mRecv[i] == j + 1) eShort = 1;
      end
      checkEq("R2", "vecValid", vecValid, mActive);
      if (mActive) checkEq("R3", "vecData", vecData, eData);
      checkEq("R4", "vecLast", vecLast, mActive && (mIdx == VC - 1));
      checkEq("R7", "resultValid", resultValid, eDone);
      checkEq("R8", "faultNets", faultNets, eFault);
      checkEq("R9", "shortSeen", shortSeen, eShort);
      if (holdPending) begin
        checkEq("R5", "stalled vecValid", vecValid, 1'b1);
        checkEq("R5", "stalled vecData", vecData, holdData);
        checkEq("R5", "stalled vecLast", vecLast, holdLast);
      end
      holdPending = vecValid && !vecReady && !start;
      holdData = vecData;
      holdLast = vecLast;
      if (vecValid && vecReady && !start && accCount < VC + 4) begin
        acc[accCount] = vecData;
        accCount++;
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  int respWords[NB];

  task automatic pulseStart();
    @(posedge clk); #2;
    start = 1'b1;
    accCount = 0;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic sendResp(int count, bit gaps);
    for (int k = 0; k < count; k++) begin
      @(posedge clk); #2;
      if (gaps && lfsr[1]) begin
        respValid = 1'b0;
        @(posedge clk); #2;
      end
      respValid = 1'b1;
      for (int i = 0; i < NB; i++) respData[i] = 1'((respWords[i] >> k) & 1);
    end
    @(posedge clk); #2;
    respValid = 1'b0;
    respData = '0;
  endtask

  task automatic waitSet();
    while (accCount < VC) @(negedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic checkCoverage();
    bit ok0, ok1, opp;
    checkEq("R3", "vectors per set", accCount, VC);
    for (int i = 0; i < NB; i++) begin
      ok0 = 0; ok1 = 0;
      for (int k = 0; k < VC; k++) begin
        if (acc[k][i]) ok1 = 1; else ok0 = 0 | ok0 | 1'b1;
      end
      checkEq("R6", "net sees 0 and 1", {ok0, ok1}, 2'b11);
      for (int j = i + 1; j < NB; j++) begin
        opp = 0;
        for (int k = 0; k < VC; k++) if (acc[k][i] != acc[k][j]) opp = 1;
        checkEq("R6", "pair driven opposite", opp, 1'b1);
      end
    end
  endtask

  task automatic checkResult(string tag, logic [NB-1:0] expFault, bit expShort);
    @(negedge clk);
    checkEq(tag, "final resultValid", resultValid, 1'b1);
    checkEq(tag, "final faultNets", faultNets, expFault);
    checkEq(tag, "final shortSeen", shortSeen, expShort);
  endtask

  task automatic goodWords();
    for (int i = 0; i < NB; i++) respWords[i] = i + 1;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    checkEq("R1", "reset vecValid", vecValid, 1'b0);
    checkEq("R1", "reset vecLast", vecLast, 1'b0);
    checkEq("R1", "reset resultValid", resultValid, 1'b0);
    checkEq("R1", "reset faultNets", faultNets, '0);
    checkEq("R1", "reset shortSeen", shortSeen, 1'b0);

    // Fault-free pass, always ready
    readyMode = 0;
    pulseStart();
    waitSet();
    checkCoverage();
    goodWords();
    sendResp(VC, 0);
    checkResult("R8", '0, 0);

    // Toggling ready, net 2 stuck low: word 0 matches no code
    readyMode = 1;
    pulseStart();
    waitSet();
    checkCoverage();
    goodWords();
    respWords[2] = 0;
    sendResp(VC, 1);
    checkResult("R8", 6'b000100, 0);

    // Wired-OR of nets 0 and 1: both read 3, the code of net 2
    readyMode = 2;
    pulseStart();
    waitSet();
    goodWords();
    respWords[0] = 3; respWords[1] = 3;
    sendResp(VC, 1);
    checkResult("R9", 6'b000011, 1);

    // Net 5 reads 7 (unassigned), extra responses ignored
    pulseStart();
    waitSet();
    goodWords();
    respWords[5] = 7;
    sendResp(VC, 0);
    for (int i = 0; i < NB; i++) respWords[i] = 0;
    sendResp(2, 0);
    checkResult("R7", 6'b100000, 0);

    // Net 3 reads code of net 4
    pulseStart();
    waitSet();
    goodWords();
    respWords[3] = 5;
    sendResp(VC, 0);
    checkResult("R9", 6'b001000, 1);

    // Restart mid-stream and mid-capture
    readyMode = 1;
    pulseStart();
    goodWords();
    respWords[0] = 0;
    sendResp(VC - 1, 0);
    pulseStart();
    @(negedge clk);
    checkEq("R10", "restart vecValid", vecValid, 1'b1);
    checkEq("R10", "restart vector 0", vecData, 6'b010101);
    checkEq("R10", "restart clears result", resultValid, 1'b0);
    goodWords();
    sendResp(VC, 0);
    checkResult("R10", '0, 0);
    waitSet();

    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule